// File: doc/BRIEF.md
# Programmable Buzzer Tone Generator

This block produces a square-wave tone for a buzzer pin. A count clock is picked by a 2-bit selector from one of four sources. Three of them are prescale taps of the main clock, with default divisors of 4, 64 and 128. The fourth is a slow subsystem clock that runs asynchronously to the main clock. The count clock advances a free-running 13-bit binary divider. A 3-bit ratio code picks which divider bit drives the pin, and that choice sets the tone frequency.

Software writes an 8-bit control byte over a byte-wide register port that has a write strobe and combinational readback. Bit 0 of the byte gates the tone onto the pin. Bits 3..1 hold the ratio code. Bits 7..4 are reserved. Some example tones: with a 5 MHz main clock on the divide-by-4 source, code 000 gives about 78.1 kHz and code 111 gives about 153 Hz. With a 32.768 kHz subclock, the same two codes give 2.048 kHz and 4 Hz.

All count clocks are delivered into the main clock domain as single-cycle enable pulses. The subclock is brought in through a two-flop synchronizer followed by a rising-edge detector.

Top module: `buzz_tone_gen`

## Requirements
- R1: When reset is released, readback is 0x00 and the buzzer pin is low.
- R2: A write stores bits 3..0 of the written byte. Bits 7..4 are always stored and read back as zero, whatever value is written.
- R3: While bit 0 of the control byte is 0, the pin is low. Clearing the bit forces the pin low in the first cycle after the write edge.
- R4: The ratio code in bits 3..1 sets the divisor of the count clock. The codes and divisors are 000 = 16, 001 = 32, 010 = 256, 011 = 512, 100 = 1024, 101 = 2048, 110 = 4096 and 111 = 8192. The output is a square wave with 50% duty, so its half period is half the divisor, counted in count-clock pulses.
- R5: Selector codes 00, 01 and 10 select the main clock divided by 2^PRE_A_LOG2, 2^PRE_B_LOG2 and 2^PRE_C_LOG2 (defaults 4, 64 and 128). Each pulse source fires once every 2^k main-clock cycles.
- R6: Selector code 11 selects the subclock. Each rising edge of sub_clk_i, once synchronized, advances the divider by exactly one step.
- R7: The divider keeps running while the output is disabled. After the enable bit is set again, the pin continues in the phase the divider would have had with no interruption.
- R8: A change of the ratio code or the selector never resets the divider. The new setting governs the tone from the next count pulse onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sub_clk_i | input | 1 | Slow subsystem clock, asynchronous to clk_i |
| clk_sel_i | input | 2 | Count clock selector |
| reg_wr_i | input | 1 | Control byte write strobe |
| reg_wdata_i | input | 8 | Control byte write data |
| reg_rdata_o | output | 8 | Control byte readback |
| buzz_o | output | 1 | Buzzer square-wave output |

## Verification
A register write that clears the enable can land in the same cycle as a divider step that raises the selected tap. The bench provokes this by waiting for a rising edge on the pin and issuing the disable write right after it, so that the write edge falls while the tone is high. The pin must read low at the next sample, whatever the divider did on that edge. A second collision occurs when a ratio or selector change meets a running divider. That case is judged by discarding the first half period after the change and then requiring the exact half period for every combination.

// File: rtl/buzz_pkg.sv
`timescale 1ns/1ps
package buzz_pkg;
  localparam int unsigned CTRL_W  = 8;
  localparam int unsigned RATIO_W = 3;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned DIV_W   = 13;
  localparam int unsigned TAP_W   = $clog2(DIV_W);

  typedef enum logic [SEL_W-1:0] {
    SRC_PRE_A = 2'b00,
    SRC_PRE_B = 2'b01,
    SRC_PRE_C = 2'b10,
    SRC_SUB   = 2'b11
  } src_sel_e;

  typedef struct packed {
    logic [CTRL_W-RATIO_W-2:0] rsv;
    logic [RATIO_W-1:0]        ratio;
    logic                      en;
  } ctrl_t;

  // log2 of the divisor: 4, 5, then 8..13
  function automatic logic [TAP_W:0] ratio_log2(input logic [RATIO_W-1:0] code);
    logic [TAP_W:0] r;
    case (code)
      3'd0:    r = 5'd4;
      3'd1:    r = 5'd5;
      default: r = 5'({2'b00, code}) + 5'd6;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/buzz_prescaler.sv
`timescale 1ns/1ps
module buzz_prescaler #(
  parameter int unsigned PRE_A_LOG2 = 2,
  parameter int unsigned PRE_B_LOG2 = 6,
  parameter int unsigned PRE_C_LOG2 = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [2:0] tick_o
);
  localparam int unsigned MAX_AB = (PRE_A_LOG2 > PRE_B_LOG2) ? PRE_A_LOG2 : PRE_B_LOG2;
  localparam int unsigned PRE_W  = (MAX_AB > PRE_C_LOG2) ? MAX_AB : PRE_C_LOG2;
  localparam int unsigned LOGS [3] = '{PRE_A_LOG2, PRE_B_LOG2, PRE_C_LOG2};

  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < 3; g++) begin : g_tap
    localparam int unsigned L = LOGS[g];
    if (L == 0) begin : g_full
      assign tick_o[g] = 1'b1;
    end else begin : g_div
      assign tick_o[g] = &cnt_q[L-1:0];
    end
  end

  if (PRE_A_LOG2 <= PRE_B_LOG2 && PRE_B_LOG2 <= PRE_C_LOG2) begin : g_nest_chk
    // R5: slower taps coincide with faster ones
    a_r5_nested_taps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o[2] |-> (tick_o[1] && tick_o[0]));
  end
endmodule

// File: rtl/buzz_sub_sync.sv
`timescale 1ns/1ps
module buzz_sub_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sub_clk_i,
  output logic pulse_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], sub_clk_i};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pulse_o = sync_q[SYNC_STAGES-1] & ~last_q;

  // R6: one pulse per subclock rising edge
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/buzz_divider.sv
`timescale 1ns/1ps
module buzz_divider
  import buzz_pkg::*;
#(
  parameter int unsigned CNT_W = DIV_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               tone_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [TAP_W:0]   tap_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign tap_idx = ratio_log2(ratio_i) - 1'b1;
  assign tone_o  = cnt_q[tap_idx[TAP_W-1:0]];

  // R7/R8: divider only moves on count pulses and is never cleared
  a_r7_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  a_r8_step_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/buzz_tone_gen.sv
`timescale 1ns/1ps
module buzz_tone_gen
  import buzz_pkg::*;
#(
  parameter int unsigned PRE_A_LOG2  = 2,
  parameter int unsigned PRE_B_LOG2  = 6,
  parameter int unsigned PRE_C_LOG2  = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sub_clk_i,
  input  logic [SEL_W-1:0]  clk_sel_i,
  input  logic              reg_wr_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  output logic [CTRL_W-1:0] reg_rdata_o,
  output logic              buzz_o
);
  ctrl_t      ctrl_q;
  logic [2:0] pre_tick;
  logic       sub_tick;
  logic       cnt_tick;
  logic       tone;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (reg_wr_i) begin
      ctrl_q.rsv   <= '0;
      ctrl_q.ratio <= reg_wdata_i[RATIO_W:1];
      ctrl_q.en    <= reg_wdata_i[0];
    end
  end

  buzz_prescaler #(
    .PRE_A_LOG2(PRE_A_LOG2),
    .PRE_B_LOG2(PRE_B_LOG2),
    .PRE_C_LOG2(PRE_C_LOG2)
  ) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(pre_tick)
  );

  buzz_sub_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sub (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sub_clk_i(sub_clk_i),
    .pulse_o  (sub_tick)
  );

  always_comb begin
    unique case (src_sel_e'(clk_sel_i))
      SRC_PRE_A: cnt_tick = pre_tick[0];
      SRC_PRE_B: cnt_tick = pre_tick[1];
      SRC_PRE_C: cnt_tick = pre_tick[2];
      default:   cnt_tick = sub_tick;
    endcase
  end

  buzz_divider u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (cnt_tick),
    .ratio_i(ctrl_q.ratio),
    .tone_o (tone)
  );

  assign buzz_o      = ctrl_q.en & tone;
  assign reg_rdata_o = ctrl_q;

  a_r2_write_masks_rsv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |=> (reg_rdata_o == {4'b0000, $past(reg_wdata_i[3:0])}));
  a_r3_disabled_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[0] |-> !buzz_o);
  a_r4_toggle_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(buzz_o) != buzz_o) && !$past(reg_wr_i) |-> $past(cnt_tick));
endmodule

// File: tb/buzz_tone_gen_tb_top.sv
`timescale 1ns/1ps
module buzz_tone_gen_tb_top;
  localparam int unsigned PA = 1, PB = 2, PC = 3;
  localparam int SUB_CYC = 10;

  logic       clk = 1'b0, rst_ni = 1'b0, sub_clk = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       buzz;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always #50 sub_clk = ~sub_clk;

  buzz_tone_gen #(.PRE_A_LOG2(PA), .PRE_B_LOG2(PB), .PRE_C_LOG2(PC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sub_clk_i(sub_clk), .clk_sel_i(sel),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .buzz_o(buzz));

  function automatic int exp_log2(input int code);
    int t [8] = '{4, 5, 8, 9, 10, 11, 12, 13};
    return t[code];
  endfunction

  function automatic int src_cycles(input int s);
    case (s)
      0: return 1 << PA;
      1: return 1 << PB;
      2: return 1 << PC;
      default: return SUB_CYC;
    endcase
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic measure(input string req, input int s, input int code);
    longint t1, t2, h;
    sel = 2'(s);
    wreg({4'b0, 3'(code), 1'b1});
    @(buzz); @(buzz); t1 = $time;
    @(buzz); t2 = $time;
    h = longint'(1 << (exp_log2(code) - 1)) * src_cycles(s) * 10;
    chk(req, t2 - t1, h);
  endtask

  initial begin
    #2500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 buzz", buzz, 0);
    repeat (200) @(negedge clk);
    chk("R1 buzz stays low", buzz, 0);

    wreg(8'hFF);
    chk("R2 reserved masked", rdata, 8'h0F);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      wreg(v);
      chk("R2 readback", rdata, {4'b0, v[3:0]});
      if (!v[0]) begin
        repeat (40) @(negedge clk);
        chk("R3 disabled low", buzz, 0);
      end
    end

    // R4: every ratio on the fastest source (ratio change without reset, R8)
    for (int c = 0; c < 8; c++) measure("R4 half period", 0, c);
    // R5 / R6: other sources
    for (int s = 1; s < 4; s++)
      for (int c = 0; c < 4; c++)
        measure(s == 3 ? "R6 sub half period" : "R5 src half period", s, c);
    // R8: random settings changed on the fly
    for (int i = 0; i < 4; i++)
      measure("R8 random switch", int'($urandom % 4), int'($urandom % 4));

    // R3: disable collides with tap going high
    sel = 2'b00;
    wreg(8'h01);
    @(posedge buzz);
    wreg(8'h00);
    chk("R3 forced low", buzz, 0);

    // R7: phase continuity across disable
    begin
      longint t0, h;
      h = 16 * (1 << PA) * 10;
      wreg(8'h03);
      @(posedge buzz); t0 = $time;
      wreg(8'h02);
      #(t0 + (h * 13) / 2 - $time);
      chk("R7 low while disabled", buzz, 0);
      wreg(8'h03);
      #(t0 + (h * 33) / 4 + 3 - $time);
      chk("R7 phase high", buzz, 1);
      #(h);
      chk("R7 phase low", buzz, 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule